// File: doc/BRIEF.md
# Multi-Channel Interval Timer with Bus Register Access

This block holds several independent 32-bit down-counters behind a simple APB-style register port. Each channel has a control word, a reload value and a live counter, all writable. A shared enable register starts and stops channels. While a channel runs, its counter drops by one per tick. A tick is either every bus clock or a synchronized rising edge of an external tick input, chosen per channel.

When a running channel ticks with its counter at zero, the counter reloads and a per-channel status flag is raised. Software clears the flag by writing a one to it. Status flags are gated by an interrupt-enable register and ORed into a single interrupt line. Software that wants a rising timestamp reads a channel's counter and inverts it. The counter can be preset while the channel is stopped, which lets the first interval differ from the periodic one.

Top module: `ival_timer`

## Requirements
- R1: After reset, every control, reload, counter, enable, interrupt-enable and status bit is zero and `irq` is low. The identity word at offset 0x00 reads as the `ID_WORD` parameter.
- R2: The register offsets are as follows: identity 0x00, channel count 0x10, interrupt enable 0x14, status 0x18, channel enable 0x1C. Channel c has its control word at 0x20+0x10·c, its reload at 0x24+0x10·c and its counter at 0x28+0x10·c. Writes to 0x00 and 0x10 are ignored.
- R3: In the enable, interrupt-enable and status registers, channel c owns bit 4·c. All other bits read as zero.
- R4: A channel counts only when three things hold: its enable bit is 1, its control bits 2:0 equal 1, and a tick arrives. With control bit 3 set to 1, every clock is a tick, and the counter drops by one per clock.
- R5: A tick that finds the counter at zero loads the reload value and sets the channel's status bit. A reload of R therefore gives a period of R+1 ticks.
- R6: With control bit 3 cleared, a tick is a rising edge of `ext_tick`, taken after a two-flop synchronizer. Bus clocks without such an edge leave the counter unchanged.
- R7: Mode codes other than 1 in control bits 2:0 keep an enabled channel idle. Its counter holds and its status is not set.
- R8: Clearing a channel's enable bit freezes its counter at its current value.
- R9: When a channel's enable bit goes from 0 to 1, its counter is loaded from the reload register. The exception is a counter write made while the channel was disabled: in that case the written value is kept.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A status set on the same clock as a clear wins.
- R11: `irq` is high exactly when some channel has both its status bit and its interrupt-enable bit set.
- R12: A counter write takes effect even while the channel runs. Counting resumes from the written value on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | AW | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| ext_tick | input | 1 | Asynchronous external tick |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that every bus access is a single setup cycle followed by a single access cycle. They also assume that no write lands on the clock edge being checked; the count, freeze and idle properties are qualified on the absence of a write. The stimulus drives each access through one task that keeps `psel` and `penable` in that order, with all writes aligned to word offsets. External tick pulses stay high and low for at least two clocks each, so the synchronizer sees every edge.

// File: rtl/ival_timer.sv
module ival_timer #(
  parameter int          NCH     = 4,
  parameter int          AW      = 8,
  parameter logic [31:0] ID_WORD = 32'h5A17_0100
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  input  logic          ext_tick,
  output logic          irq
);
  localparam logic [AW-1:0] A_ID   = AW'(8'h00);
  localparam logic [AW-1:0] A_CFG  = AW'(8'h10);
  localparam logic [AW-1:0] A_IE   = AW'(8'h14);
  localparam logic [AW-1:0] A_STS  = AW'(8'h18);
  localparam logic [AW-1:0] A_EN   = AW'(8'h1C);

  logic [NCH-1:0][31:0] cnt_r, rld_r;
  logic [NCH-1:0][3:0]  ctl_r;
  logic [NCH-1:0]       en_r, ie_r, sts_r, pre_r;
  logic [2:0]           xs_r;

  wire wr       = psel & penable & pwrite;
  wire ext_rise = xs_r[1] & ~xs_r[2];

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) xs_r <= '0;
    else          xs_r <= {xs_r[1:0], ext_tick};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] BASE = AW'(32'h20 + 32'h10 * c);
    wire w_ctl   = wr && paddr == BASE;
    wire w_rld   = wr && paddr == BASE + AW'(4);
    wire w_cnt   = wr && paddr == BASE + AW'(8);
    wire w_en    = wr && paddr == A_EN;
    wire en_rise = w_en && pwdata[4*c] && !en_r[c];
    wire run     = en_r[c] && ctl_r[c][2:0] == 3'd1 && (ctl_r[c][3] || ext_rise);
    wire expire  = run && cnt_r[c] == '0;

    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
        cnt_r[c] <= '0;
        rld_r[c] <= '0;
        ctl_r[c] <= '0;
        en_r[c]  <= 1'b0;
        ie_r[c]  <= 1'b0;
        sts_r[c] <= 1'b0;
        pre_r[c] <= 1'b0;
      end else begin
        if (w_ctl) ctl_r[c] <= pwdata[3:0];
        if (w_rld) rld_r[c] <= pwdata;
        if (w_en)  en_r[c]  <= pwdata[4*c];
        if (wr && paddr == A_IE) ie_r[c] <= pwdata[4*c];

        if (w_cnt) begin
          cnt_r[c] <= pwdata;
          if (!en_r[c]) pre_r[c] <= 1'b1;
        end else if (en_rise) begin
          if (!pre_r[c]) cnt_r[c] <= rld_r[c];
          pre_r[c] <= 1'b0;
        end else if (run) begin
          cnt_r[c] <= expire ? rld_r[c] : cnt_r[c] - 32'd1;
        end

        if (expire) sts_r[c] <= 1'b1;
        else if (wr && paddr == A_STS && pwdata[4*c]) sts_r[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      A_ID:  prdata = ID_WORD;
      A_CFG: prdata = 32'(NCH);
      A_IE:  for (int c = 0; c < NCH; c++) prdata[4*c] = ie_r[c];
      A_STS: for (int c = 0; c < NCH; c++) prdata[4*c] = sts_r[c];
      A_EN:  for (int c = 0; c < NCH; c++) prdata[4*c] = en_r[c];
      default: ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (paddr == AW'(32'h20 + 32'h10 * c)) prdata = {28'd0, ctl_r[c]};
      if (paddr == AW'(32'h24 + 32'h10 * c)) prdata = rld_r[c];
      if (paddr == AW'(32'h28 + 32'h10 * c)) prdata = cnt_r[c];
    end
  end

  assign irq = |(sts_r & ie_r);
endmodule

// File: rtl/ival_timer_chk.sv
module ival_timer_chk #(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input logic                 pclk,
  input logic                 presetn,
  input logic                 wr,
  input logic [AW-1:0]        paddr,
  input logic [31:0]          pwdata,
  input logic [NCH-1:0][31:0] cnt,
  input logic [NCH-1:0][31:0] rld,
  input logic [NCH-1:0][3:0]  ctl,
  input logic [NCH-1:0]       en,
  input logic [NCH-1:0]       ie,
  input logic [NCH-1:0]       sts,
  input logic                 irq
);
  assert_irq_masked_R11: assert property (@(posedge pclk) disable iff (!presetn)
    (ie == '0) |-> !irq);

  for (genvar c = 0; c < NCH; c++) begin : g_a
    wire bus_run = en[c] && ctl[c] == 4'h9;

    assert_count_down_R4: assert property (@(posedge pclk) disable iff (!presetn)
      (bus_run && cnt[c] != '0 && !wr) |=> cnt[c] == $past(cnt[c]) - 32'd1);

    assert_reload_R5: assert property (@(posedge pclk) disable iff (!presetn)
      (bus_run && cnt[c] == '0 && !wr) |=> (cnt[c] == $past(rld[c]) && sts[c]));

    assert_idle_mode_R7: assert property (@(posedge pclk) disable iff (!presetn)
      (ctl[c][2:0] != 3'd1 && !wr) |=> $stable(cnt[c]));

    assert_frozen_R8: assert property (@(posedge pclk) disable iff (!presetn)
      (!en[c] && !wr) |=> $stable(cnt[c]));

    assert_w1c_R10: assert property (@(posedge pclk) disable iff (!presetn)
      (wr && paddr == AW'(8'h18) && pwdata[4*c] && !en[c]) |=> !sts[c]);
  end
endmodule

bind ival_timer ival_timer_chk #(.NCH(NCH), .AW(AW)) chk_i (
  .pclk(pclk), .presetn(presetn), .wr(wr), .paddr(paddr), .pwdata(pwdata),
  .cnt(cnt_r), .rld(rld_r), .ctl(ctl_r), .en(en_r), .ie(ie_r), .sts(sts_r),
  .irq(irq)
);

// File: tb/ival_timer_tb_top.sv
module ival_timer_tb_top;
  localparam int          CLK_P = 10;
  localparam int          NCH   = 4;
  localparam logic [31:0] IDW   = 32'h5A17_0100;

  logic        pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0, ext_tick = 0;
  logic [7:0]  paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  ival_timer #(.NCH(NCH), .AW(8), .ID_WORD(IDW)) dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_tick(ext_tick), .irq(irq));

  always #(CLK_P/2) pclk = ~pclk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic wait_n(int k);
    repeat (k) @(negedge pclk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'd0, irq}, 0);
    rd(8'h00, v); chk("R1 id", v, IDW);
    rd(8'h18, v); chk("R1 status", v, 0);
    rd(8'h1C, v); chk("R1 enable", v, 0);
    rd(8'h28, v); chk("R1 counter", v, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(8'h00, 32'h0); rd(8'h00, v); chk("R2 id ignores write", v, IDW);
    wr(8'h10, 32'h77); rd(8'h10, v); chk("R2 channel count", v, NCH);
    wr(8'h44, 32'h1234_5678); rd(8'h44, v); chk("R2 ch2 reload", v, 32'h1234_5678);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v); chk("R3 ie bits", v, 32'h0000_1111);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_busclk();
    logic [31:0] v;
    wr(8'h20, 32'h9); wr(8'h24, 32'd100);
    wr(8'h1C, 32'h1); wait_n(7); wr(8'h1C, 32'h0);
    rd(8'h28, v); chk("R4 ten bus ticks", v, 32'd90);
    rd(8'h18, v); chk("R5 no early status", v, 0);
    wait_n(20); rd(8'h28, v); chk("R8 frozen", v, 32'd90);
  endtask

  task automatic t_period();
    logic [31:0] v;
    wr(8'h24, 32'd9);
    wr(8'h1C, 32'h1); wait_n(12); wr(8'h1C, 32'h0);
    rd(8'h28, v); chk("R5 wrap after 15 ticks", v, 32'd4);
    rd(8'h18, v); chk("R5 status set", v, 32'h1);
    wr(8'h18, 32'hFFFF_FFFF);
  endtask

  task automatic t_ext();
    logic [31:0] v;
    wr(8'h40, 32'h1); wr(8'h44, 32'd100);
    wr(8'h1C, 32'h100);
    for (int i = 0; i < 5; i++) begin
      @(negedge pclk); ext_tick = 1; wait_n(2); ext_tick = 0; wait_n(2);
    end
    wait_n(6); wr(8'h1C, 32'h0);
    rd(8'h48, v); chk("R6 five external edges", v, 32'd95);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    wr(8'h40, 32'hA); wr(8'h44, 32'd77);
    wr(8'h1C, 32'h100); wait_n(10);
    rd(8'h48, v); chk("R7 idle mode holds", v, 32'd77);
    rd(8'h18, v); chk("R7 no status", v, 0);
    wr(8'h1C, 32'h0);
  endtask

  task automatic t_preset();
    logic [31:0] v;
    wr(8'h50, 32'h9); wr(8'h54, 32'd200); wr(8'h58, 32'd50);
    wr(8'h1C, 32'h1000); wait_n(5); wr(8'h1C, 32'h0);
    rd(8'h58, v); chk("R9 preset kept", v, 32'd42);
    wr(8'h1C, 32'h1000); wait_n(5); wr(8'h1C, 32'h0);
    rd(8'h58, v); chk("R9 reload on enable", v, 32'd192);
  endtask

  task automatic t_w1c_irq();
    logic [31:0] v;
    wr(8'h20, 32'h9); wr(8'h24, 32'd3);
    wr(8'h30, 32'h9); wr(8'h34, 32'd3);
    wr(8'h1C, 32'h11); wait_n(10); wr(8'h1C, 32'h0);
    rd(8'h18, v); chk("R5 two status bits", v, 32'h11);
    chk("R11 masked", {31'd0, irq}, 0);
    wr(8'h14, 32'h10); #1 chk("R11 raised", {31'd0, irq}, 1);
    wr(8'h18, 32'h0); rd(8'h18, v); chk("R10 zero write", v, 32'h11);
    wr(8'h18, 32'h10); rd(8'h18, v); chk("R10 clear one", v, 32'h01);
    chk("R11 dropped", {31'd0, irq}, 0);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); chk("R10 clear all", v, 0);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_live_write();
    logic [31:0] v;
    wr(8'h34, 32'd1000);
    wr(8'h1C, 32'h10); wr(8'h38, 32'd20); wr(8'h1C, 32'h0);
    rd(8'h38, v); chk("R12 running write", v, 32'd17);
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1;
    t_reset();
    t_map();
    t_busclk();
    t_period();
    t_ext();
    t_mode();
    t_preset();
    t_w1c_irq();
    t_live_write();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge pclk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule